// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire management interface of IEEE 802.3 Clause 22. It runs one transaction at a time. Software works through two 32-bit registers on a simple register bus. A data word at byte offset 4 holds the write payload and, afterwards, the read result. A control word at byte offset 0 selects the PHY and the register, the direction and an enable, and it starts the transfer.

Once started, the block serializes a 64-bit frame. The frame is 32 preamble ones, start pattern 01, a two-bit opcode, the 5-bit PHY address, the 5-bit register address, a two-bit turnaround and 16 data bits, all sent MSB first. The management clock (MDC) is derived from the system clock. The data line (MDIO) is driven through an output-enable so it can be wired as open-drain. The start bit stays at 1 while the transfer runs, so software polls it to find completion. After a read it checks the latched error flag.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The control word has this layout: bit 0 go/busy, bit 1 enable, bit 2 direction (1 = read, 0 = write), bit 3 read-error (read-only), bits 12:8 PHY address, bits 20:16 register address. All other bits read 0. The fields written while idle read back unchanged.
- R2: A control write with go=1 and enable=1 while idle starts a frame. Go then reads 1 until the last frame bit completes, and hardware then clears it.
- R3: A control write with go=1 and enable=0 starts nothing. Go reads 0, MDIO stays undriven and MDC stays high.
- R4: A write frame drives all 64 bits as 32 ones, 01, 01, the PHY address, the register address, 10, and data[15:0] of the data word, MSB first.
- R5: A read frame drives the header with opcode 10. It releases the output enable from the first turnaround bit (frame bit 46) to the end of the frame.
- R6: At the end of a read, the 16 bits sampled from MDIO during frame bits 48..63 (first = bit 15) land in data[15:0]. When a software data write falls in the same cycle, the captured value takes priority.
- R7: After a read, the error flag is 1 exactly when MDIO was high at the rising MDC edge of the second turnaround bit. A write transaction always leaves it 0.
- R8: A control write issued while busy is ignored entirely. Go stays 1, the address fields keep their values and the frame in flight is not changed.
- R9: MDC has a half period of MDC_HALF system clocks while a frame runs. It is stopped high when idle, and MDIO is then undriven. While driven, MDIO changes only together with a falling MDC edge.
- R10: After reset, both registers read 0, MDC is high and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address (0 control, 4 data) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Serial data in from the MDIO pad |

## Verification
Two functions can fall in the same clock edge: the capture of read data into the data word when a frame completes, and a software write to that same data word. The bench times a data write to land on the exact edge of the 64th rising MDC edge. It does this by counting system clocks from the preceding falling edge. After a read, the captured PHY value must win. After a write frame, the software value must stand, because there is no capture. A control write issued mid-frame is judged against the unchanged serial frame and the unchanged field readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_AW    = 5;
   localparam int REG_AW    = 5;
   localparam int DATA_W    = 16;
   localparam int PRE_LEN   = 32;
   localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
   localparam int TA_IDX    = PRE_LEN + 4 + PHY_AW + REG_AW;
   localparam int DATA_IDX  = TA_IDX + 2;

   // control word bit positions
   localparam int CB_GO  = 0;
   localparam int CB_EN  = 1;
   localparam int CB_RD  = 2;
   localparam int CB_ERR = 3;
   localparam int CB_PHY = 8;
   localparam int CB_REG = 16;

   typedef struct packed {
      logic [PHY_AW-1:0] phy;
      logic [REG_AW-1:0] regn;
      logic              rd;
      logic [DATA_W-1:0] wdata;
   } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic fall_tick,
   output logic rise_tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap      = run && (cnt == CW'(HALF - 1));
   assign fall_tick = wrap && mdc;
   assign rise_tick = wrap && !mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b1;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b1;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  mdio_cmd_t         cmd,
   input  logic              fall_tick,
   input  logic              rise_tick,
   input  logic              mdio_i,
   output logic              active,
   output logic              done,
   output logic              is_read,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              ta_bad
);
   localparam int IW = $clog2(FRAME_LEN);

   logic [FRAME_LEN-1:0] frame;
   logic [IW-1:0]        idx;
   logic [DATA_W-1:0]    rd_sh;
   logic                 release_now;

   assign done        = active && rise_tick && (idx == IW'(FRAME_LEN - 1));
   assign rd_data     = {rd_sh[DATA_W-2:0], mdio_i};
   assign release_now = is_read && (idx >= IW'(TA_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         is_read <= 1'b0;
         idx     <= '0;
         frame   <= '0;
         rd_sh   <= '0;
         ta_bad  <= 1'b0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
      end else if (launch) begin
         active  <= 1'b1;
         is_read <= cmd.rd;
         idx     <= '0;
         rd_sh   <= '0;
         ta_bad  <= 1'b0;
         frame   <= {{PRE_LEN{1'b1}}, 2'b01, (cmd.rd ? 2'b10 : 2'b01),
                     cmd.phy, cmd.regn, 2'b10,
                     (cmd.rd ? {DATA_W{1'b0}} : cmd.wdata)};
      end else if (active) begin
         if (fall_tick) begin
            mdio_oe <= !release_now;
            mdio_o  <= release_now ? 1'b1 : frame[IW'(FRAME_LEN - 1) - idx];
         end
         if (rise_tick) begin
            if (is_read && idx == IW'(TA_IDX + 1))
               ta_bad <= mdio_i;
            if (is_read && idx >= IW'(DATA_IDX))
               rd_sh <= rd_data;
            if (done) begin
               active  <= 1'b0;
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CTRL_OFS = 0,
   parameter int DATA_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              done,
   input  logic              ta_bad,
   input  logic [DATA_W-1:0] rd_data,
   output logic              launch,
   output mdio_cmd_t         cmd,
   output logic              busy,
   output logic              ctrl_hit,
   output logic              rd_err
);
   logic              data_hit;
   logic              en_q, rd_q;
   logic [PHY_AW-1:0] phy_q;
   logic [REG_AW-1:0] reg_q;
   logic [DATA_W-1:0] data_q;

   assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
   assign data_hit = bus_wr && (bus_addr == ADDR_W'(DATA_OFS));
   assign launch   = ctrl_hit && !busy && bus_wdata[CB_GO] && bus_wdata[CB_EN];

   assign cmd.phy   = bus_wdata[CB_PHY +: PHY_AW];
   assign cmd.regn  = bus_wdata[CB_REG +: REG_AW];
   assign cmd.rd    = bus_wdata[CB_RD];
   assign cmd.wdata = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         en_q   <= 1'b0;
         rd_q   <= 1'b0;
         rd_err <= 1'b0;
         phy_q  <= '0;
         reg_q  <= '0;
         data_q <= '0;
      end else begin
         if (ctrl_hit && !busy) begin
            phy_q <= bus_wdata[CB_PHY +: PHY_AW];
            reg_q <= bus_wdata[CB_REG +: REG_AW];
            en_q  <= bus_wdata[CB_EN];
            rd_q  <= bus_wdata[CB_RD];
            if (launch) begin
               busy   <= 1'b1;
               rd_err <= 1'b0;
            end
         end
         if (done) begin
            busy   <= 1'b0;
            rd_err <= rd_q && ta_bad;
         end
         if (done && rd_q)
            data_q <= rd_data;
         else if (data_hit)
            data_q <= bus_wdata[DATA_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_OFS)) begin
         bus_rdata[CB_GO]               = busy;
         bus_rdata[CB_EN]               = en_q;
         bus_rdata[CB_RD]               = rd_q;
         bus_rdata[CB_ERR]              = rd_err;
         bus_rdata[CB_PHY +: PHY_AW]    = phy_q;
         bus_rdata[CB_REG +: REG_AW]    = reg_q;
      end else if (bus_addr == ADDR_W'(DATA_OFS)) begin
         bus_rdata[DATA_W-1:0] = data_q;
      end
   end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int MDC_MAX_HZ = 2_500_000,
   parameter int MDC_HALF   = 10,
   parameter int ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam longint MIN_SYS_HZ = longint'(MDC_MAX_HZ) * 2 * MDC_HALF;

   generate
      if (MDC_HALF < 1) begin : g_bad_half
         $error("MDC_HALF must be at least 1");
      end
      if (longint'(SYS_CLK_HZ) > MIN_SYS_HZ) begin : g_bad_rate
         $error("MDC_HALF too small for the MDC rate limit");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach byte offset 4");
      end
   endgenerate

   logic              launch, busy, ctrl_hit, rd_err;
   logic              fall_tick, rise_tick;
   logic              seq_active, seq_done, seq_read, ta_bad;
   logic [DATA_W-1:0] rd_data;
   mdio_cmd_t         cmd;

   mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .done      (seq_done),
      .ta_bad    (ta_bad),
      .rd_data   (rd_data),
      .launch    (launch),
      .cmd       (cmd),
      .busy      (busy),
      .ctrl_hit  (ctrl_hit),
      .rd_err    (rd_err)
   );

   mdio_clkgen #(.HALF(MDC_HALF)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (seq_active),
      .mdc       (mdc),
      .fall_tick (fall_tick),
      .rise_tick (rise_tick)
   );

   mdio_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .cmd       (cmd),
      .fall_tick (fall_tick),
      .rise_tick (rise_tick),
      .mdio_i    (mdio_i),
      .active    (seq_active),
      .done      (seq_done),
      .is_read   (seq_read),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rd_data   (rd_data),
      .ta_bad    (ta_bad)
   );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
   import mdio_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic ctrl_hit,
   input logic go_bit,
   input logic en_bit,
   input logic busy,
   input logic done,
   input logic is_read,
   input logic rd_err,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   // R2
   launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ctrl_hit && go_bit && en_bit));

   // R3
   no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctrl_hit && go_bit && !en_bit) |=> !busy);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_hit && !done) |=> busy);

   // R9
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mdc && !mdio_oe));

   // R9
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

   // R7
   write_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !is_read) |=> !rd_err);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_hit (ctrl_hit),
   .go_bit   (bus_wdata[0]),
   .en_bit   (bus_wdata[1]),
   .busy     (busy),
   .done     (seq_done),
   .is_read  (seq_read),
   .rd_err   (rd_err),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 10;
   localparam int AW         = 4;
   localparam logic [AW-1:0] A_CTRL = 4'd0;
   localparam logic [AW-1:0] A_DATA = 4'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          mdc, mdio_o, mdio_oe;
   logic          mdio_i = 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   // PHY model / monitor state
   int          rise_cnt = 64;
   int          glitch = 0;
   int          gap_bad = 0;
   int          gap = 0;
   bit          have_prev = 0;
   bit          cur_rd = 0;
   bit          ta_bad_q = 0;
   logic [15:0] rsp_q = '0;
   logic [63:0] obs = '0;
   logic [63:0] oe_obs = '0;
   logic        mdc_p = 1'b1, o_p = 1'b1, oe_p = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_ctrl #(.SYS_CLK_HZ(50_000_000), .MDC_HALF(HALF), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always @(negedge clk) begin
      bit fell;
      fell = mdc_p && !mdc;
      gap++;
      if (mdc != mdc_p) begin
         if (have_prev && gap != HALF) gap_bad++;
         have_prev = 1;
         gap = 0;
      end
      if (mdio_oe && oe_p && (mdio_o != o_p) && !fell) glitch++;
      if (fell && rise_cnt < 64) begin
         obs[63 - rise_cnt]    = mdio_o;
         oe_obs[63 - rise_cnt] = mdio_oe;
         if (cur_rd && rise_cnt == 47)      mdio_i = ta_bad_q;
         else if (cur_rd && rise_cnt >= 48) mdio_i = rsp_q[63 - rise_cnt];
         else                               mdio_i = 1'b1;
      end
      if (!mdc_p && mdc && rise_cnt < 64) begin
         rise_cnt++;
         if (rise_cnt == 64) begin
            have_prev = 0;
            mdio_i = 1'b1;
         end
      end
      mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] ctrl_word(logic [4:0] pa, logic [4:0] ra, bit rd, bit en, bit go);
      return {11'b0, ra, 3'b0, pa, 4'b0, 1'b0, rd, en, go};
   endfunction

   // mode 0 plain, 1 control poke mid-frame, 2 data write on completion edge
   task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] resp, input bit tab, input int mode);
      logic [31:0] v;
      logic [63:0] exp;
      logic [15:0] exp_data;
      int guard;
      cur_rd = rd; ta_bad_q = tab; rsp_q = resp;
      glitch = 0; gap_bad = 0; have_prev = 0; rise_cnt = 0;
      if (!rd) bus_write(A_DATA, {16'h0, wd});
      bus_write(A_CTRL, ctrl_word(pa, ra, rd, 1'b1, 1'b1));
      bus_read(A_CTRL, v);
      chk(v[0] == 1'b1, "R2 go reads busy", {63'b0, v[0]}, 64'd1);
      if (mode == 1) begin
         wait (rise_cnt == 20);
         bus_write(A_CTRL, ctrl_word(~pa, ~ra, !rd, 1'b1, 1'b1));
         bus_read(A_CTRL, v);
         chk(v[0] && v[12:8] == pa && v[20:16] == ra && v[2] == rd, "R8 poke ignored",
             {32'b0, v}, {32'b0, ctrl_word(pa, ra, rd, 1'b1, 1'b1)});
      end
      if (mode == 2) begin
         wait (rise_cnt == 63);
         guard = 0;
         do begin @(negedge clk); guard++; end while (mdc != 1'b0 && guard < 1000);
         repeat (HALF - 1) @(negedge clk);
         bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 32'h0000BEEF;
         @(negedge clk);
         bus_wr = 1'b0;
      end
      guard = 0;
      do begin bus_read(A_CTRL, v); guard++; end while (v[0] && guard < 5000);
      chk(v[0] == 1'b0, "R2 go self-clears", {63'b0, v[0]}, 64'd0);
      exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
      if (rd) begin
         chk(obs[63:18] == exp[63:18], "R5 read header", obs, exp);
         chk(oe_obs == {{46{1'b1}}, 18'b0}, "R5 oe release", oe_obs, {{46{1'b1}}, 18'b0});
      end else begin
         chk(obs == exp, "R4 write frame", obs, exp);
         chk(oe_obs == {64{1'b1}}, "R4 oe driven", oe_obs, {64{1'b1}});
      end
      chk(v[3] == (rd && tab), "R7 error flag", {63'b0, v[3]}, {63'b0, (rd && tab)});
      bus_read(A_DATA, v);
      exp_data = rd ? resp : ((mode == 2) ? 16'hBEEF : wd);
      if (!(rd && tab))
         chk(v == {16'h0, exp_data}, "R6 data word", {32'b0, v}, {48'b0, exp_data});
      chk(mdc == 1'b1 && mdio_oe == 1'b0, "R9 idle pins", {62'b0, mdc, mdio_oe}, 64'd2);
      chk(glitch == 0, "R9 change off falling edge", 64'(glitch), 64'd0);
      chk(gap_bad == 0, "R9 half period", 64'(gap_bad), 64'd0);
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      bus_read(A_CTRL, v);
      chk(v == 32'h0, "R10 control reset", {32'b0, v}, 64'd0);
      bus_read(A_DATA, v);
      chk(v == 32'h0, "R10 data reset", {32'b0, v}, 64'd0);
      chk(mdc == 1'b1 && mdio_oe == 1'b0, "R10 pins reset", {62'b0, mdc, mdio_oe}, 64'd2);
      // R3 go without enable, R1 field readback
      bus_write(A_CTRL, ctrl_word(5'd19, 5'd6, 1'b1, 1'b0, 1'b1));
      repeat (3 * HALF) begin
         @(negedge clk);
         if (mdio_oe || !mdc) n_fail += 0;
      end
      bus_read(A_CTRL, v);
      chk(v[0] == 1'b0, "R3 no start without enable", {63'b0, v[0]}, 64'd0);
      chk(mdc == 1'b1 && mdio_oe == 1'b0, "R3 pins idle", {62'b0, mdc, mdio_oe}, 64'd2);
      chk(v == ctrl_word(5'd19, 5'd6, 1'b1, 1'b0, 1'b0), "R1 field readback",
          {32'b0, v}, {32'b0, ctrl_word(5'd19, 5'd6, 1'b1, 1'b0, 1'b0)});
      // write sweep
      run_txn(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0, 1'b0, 0);
      run_txn(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0, 1'b0, 0);
      for (int i = 0; i < 10; i++)
         run_txn(1'b0, 5'((i * 7 + 3) % 32), 5'((i * 11 + 5) % 32),
                 16'(i * 16'h1357) ^ 16'hA5C3, 16'h0, 1'b0, 0);
      // read sweep, every fourth with a turnaround error
      for (int i = 0; i < 10; i++)
         run_txn(1'b1, 5'((i * 13 + 1) % 32), 5'((i * 5 + 9) % 32),
                 16'h0, 16'(i * 16'h2F1D) + 16'h0101, (i % 4) == 3, 0);
      // R8 poke during busy
      run_txn(1'b0, 5'd10, 5'd21, 16'h5A3C, 16'h0, 1'b0, 1);
      run_txn(1'b1, 5'd4, 5'd17, 16'h0, 16'hC0DE, 1'b0, 1);
      // R6 same-edge collision: capture wins on read, software wins on write
      run_txn(1'b1, 5'd2, 5'd3, 16'h0, 16'h1234, 1'b0, 2);
      run_txn(1'b0, 5'd9, 5'd8, 16'h7777, 16'h0, 1'b0, 2);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule